// File: doc/BRIEF.md
# Supply and Bus Power Mode Sequencer

This block is the mode controller of a small automotive supply-and-transceiver chip. It takes digital flags from the supply comparators, the regulator output monitor, the temperature sensor and the bus wakeup filter, plus two host pins: the enable pin and the transmit-data pin. From these it steps the chip through six modes: Shutdown, Reset, Normal, Standby, Sleep and Thermal. It drives the active-low reset pin for the host, the regulator enable, a two-bit transceiver mode and the receive-data pin.

The host moves the chip into a low-power mode by dropping the enable pin while Normal. A fixed number of cycles later the transmit-data pin is sampled. High selects Standby, where the regulator stays on. Low selects Sleep, where it is switched off. In every mode where the transceiver listens for the bus, a detected wakeup pulls the receive-data pin low and keeps it low until the host has brought the chip back to Normal. A low supply overrides every other condition at once, and the regulator enable and reset pin follow it without waiting for a clock edge.

Top module: `pwr_mode_seq`

## Requirements
- R1: While the block reset `rst_n` is low, and on the first cycle after it is released, the outputs show Shutdown: `rstn_o`=0, `vreg_en_o`=0, `lin_mode_o`=2'b00 (passive), `rxd_o`=1.
- R2: When `vs_low_i` is high, the outputs take their Shutdown values in the same cycle, without a clock edge. The mode is Shutdown from the next edge, whatever the mode was before.
- R3: Shutdown is left only when `vs_high_i` is high, `vs_low_i` is low and `overtemp_i` is low. The next mode is always Reset.
- R4: In Reset, `rstn_o`=0, `vreg_en_o`=1 and `lin_mode_o`=2'b00. With `vout_uv_i` low, Reset lasts exactly RST_CYC cycles. Each cycle with `vout_uv_i` high restarts this count.
- R5: When Reset ends, the next mode is Normal if the synchronized enable is high and Standby if it is low. `rstn_o` goes high at that point.
- R6: In Normal, `lin_mode_o`=2'b10 (active), `vreg_en_o`=1, `rstn_o`=1, and `rxd_o` follows `lin_rx_i`. Standby moves to Normal when the synchronized enable is high.
- R7: In Normal, a low synchronized enable starts a request. After SEL_CYC cycles the synchronized `txd_i` is sampled: high gives Standby (`lin_mode_o`=2'b01, regulator on), low gives Sleep (`lin_mode_o`=2'b01, regulator off, `rstn_o`=1). Sleep is reached in no other way.
- R8: If the synchronized enable goes high again before the sample is taken, the request is dropped and the block stays in Normal.
- R9: A pulse on `lin_wake_i` in Standby, Sleep or Thermal sets a pending wakeup. Outside Normal it drives `rxd_o` low, and it is cleared only by being in Normal or Shutdown.
- R10: In Sleep, `lin_wake_i` or a high synchronized enable moves the block to Reset. `vout_uv_i` is ignored in Sleep.
- R11: `overtemp_i` moves the block from Reset, Normal, Standby or Sleep to Thermal (`rstn_o`=0, `vreg_en_o`=0, `lin_mode_o`=2'b01). Thermal returns to Reset once `overtemp_i` is low.
- R12: `vout_uv_i` in Normal or Standby moves the block to Reset.
- R13: The priority is fixed: low supply first, then over-temperature, then regulator undervoltage, then host requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| vs_high_i | input | 1 | Supply is above the upper power-on level |
| vs_low_i | input | 1 | Supply is below the lower power-on level |
| vout_uv_i | input | 1 | Regulator output is below its monitor threshold |
| overtemp_i | input | 1 | Junction over-temperature flag |
| lin_wake_i | input | 1 | One-cycle pulse from the bus wakeup filter |
| lin_rx_i | input | 1 | Receiver data from the transceiver |
| en_i | input | 1 | Host enable pin (asynchronous) |
| txd_i | input | 1 | Host transmit-data pin (asynchronous) |
| rstn_o | output | 1 | Active-low reset to the host |
| vreg_en_o | output | 1 | Regulator enable |
| lin_mode_o | output | 2 | Transceiver mode: 00 passive, 01 wakeup, 10 active |
| rxd_o | output | 1 | Receive data or wakeup indication to the host |

## Verification
A wrong mode register is visible at the ports on the next cycle, because each mode has its own combination of reset pin, regulator enable and transceiver mode. The exception is the pending-wakeup flag, which shows only on `rxd_o` and only outside Normal. A counter that is off by one moves the Reset exit or the low-power decision by one cycle. The bench's cycle model reports this on the cycle where the edge of `rstn_o` or `lin_mode_o` fails to appear. A lost or stuck wakeup latch shows up at the next wakeup-capable mode, or at the first Normal cycle where `rxd_o` should follow `lin_rx_i`.

// File: rtl/pms_pkg.sv
// Package: shared mode and transceiver encodings for the power mode sequencer.
// Assumes: consumers compare against these names only, never raw codes.
package pms_pkg;

    typedef enum logic [2:0] {
        MODE_SHDN    = 3'd0,
        MODE_RESET   = 3'd1,
        MODE_NORMAL  = 3'd2,
        MODE_STANDBY = 3'd3,
        MODE_SLEEP   = 3'd4,
        MODE_THERMAL = 3'd5
    } pms_mode_e;

    typedef enum logic [1:0] {
        LIN_PASSIVE = 2'b00,
        LIN_WAKE    = 2'b01,
        LIN_ACTIVE  = 2'b10
    } pms_lin_e;

endpackage

// File: rtl/pms_sync.sv
// Module: multi-stage synchronizer for asynchronous host pins.
// Assumes: each bit is independent; RST_VAL is the pin's idle level.
module pms_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the pin value one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pms_timer.sv
// Module: loadable down-counter shared by the reset window and the
// mode-select delay. done_o is high when the count has reached zero.
// Assumes: the controller never decrements a counter already at zero.
module pms_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: load takes priority over decrement; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> !done_o) else $error("timer wrapped"); // R4

endmodule

// File: rtl/pms_wake_latch.sv
// Module: pending-wakeup flag. Set by a wakeup pulse in a listening mode,
// cleared by Normal or Shutdown.
// Assumes: set and clear are never requested in the same cycle.
module pms_wake_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    // Purpose: hold a detected wakeup until the controller releases it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
        end else if (clr_i) begin
            pend_o <= 1'b0;
        end else if (set_i) begin
            pend_o <= 1'b1;
        end
    end

    AST_WAKE_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_i && clr_i)) else $error("wake set and clear together"); // R9

endmodule

// File: rtl/pwr_mode_seq.sv
// Module: power mode sequencer. Steps through Shutdown, Reset, Normal,
// Standby, Sleep and Thermal from supply, temperature, undervoltage and
// wakeup flags and the host enable / transmit-data pins.
// Assumes: the flag inputs are already synchronous to clk; en_i and txd_i
// are asynchronous and are synchronized here. A low supply forces the
// outputs to their Shutdown values combinationally.
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int RST_CYC  = 64,
    parameter int SEL_CYC  = 16,
    parameter int SYNC_STG = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vs_high_i,
    input  logic       vs_low_i,
    input  logic       vout_uv_i,
    input  logic       overtemp_i,
    input  logic       lin_wake_i,
    input  logic       lin_rx_i,
    input  logic       en_i,
    input  logic       txd_i,
    output logic       rstn_o,
    output logic       vreg_en_o,
    output logic [1:0] lin_mode_o,
    output logic       rxd_o
);

    localparam int TMAX  = (RST_CYC > SEL_CYC) ? RST_CYC : SEL_CYC;
    localparam int CNT_W = $clog2(TMAX + 1);
    localparam logic [CNT_W-1:0] RST_LD = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] SEL_LD = CNT_W'(SEL_CYC - 1);

    pms_mode_e        mode_q, mode_d;
    logic             en_s, txd_s;
    logic             tmr_load, tmr_dec, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             wake_set, wake_clr, wake_pend;
    logic             listening;

    pms_sync #(.WIDTH(1), .STAGES(SYNC_STG), .RST_VAL(1'b0)) i_en_sync (
        .clk(clk), .rst_n(rst_n), .d_i(en_i), .q_o(en_s));

    pms_sync #(.WIDTH(1), .STAGES(SYNC_STG), .RST_VAL(1'b1)) i_txd_sync (
        .clk(clk), .rst_n(rst_n), .d_i(txd_i), .q_o(txd_s));

    pms_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
        .dec_i(tmr_dec), .done_o(tmr_done));

    assign listening = (mode_q == MODE_STANDBY) || (mode_q == MODE_SLEEP) ||
                       (mode_q == MODE_THERMAL);
    assign wake_set  = lin_wake_i && !vs_low_i && listening;
    assign wake_clr  = (mode_q == MODE_NORMAL) || (mode_q == MODE_SHDN);

    pms_wake_latch i_wake (
        .clk(clk), .rst_n(rst_n), .set_i(wake_set), .clr_i(wake_clr),
        .pend_o(wake_pend));

    // Purpose: next mode and timer control, highest-priority condition first.
    always_comb begin
        mode_d   = mode_q;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        tmr_val  = RST_LD;
        if (vs_low_i) begin
            mode_d = MODE_SHDN;
        end else if (mode_q == MODE_SHDN) begin
            if (vs_high_i && !overtemp_i) begin
                mode_d   = MODE_RESET;
                tmr_load = 1'b1;
            end
        end else if (mode_q == MODE_THERMAL) begin
            if (!overtemp_i) begin
                mode_d   = MODE_RESET;
                tmr_load = 1'b1;
            end
        end else if (overtemp_i) begin
            mode_d = MODE_THERMAL;
        end else if (vout_uv_i && (mode_q != MODE_SLEEP)) begin
            mode_d   = MODE_RESET;
            tmr_load = 1'b1;
        end else begin
            case (mode_q)
                MODE_RESET: begin
                    if (tmr_done) begin
                        mode_d   = en_s ? MODE_NORMAL : MODE_STANDBY;
                        tmr_load = 1'b1;
                        tmr_val  = SEL_LD;
                    end else begin
                        tmr_dec = 1'b1;
                    end
                end
                MODE_NORMAL: begin
                    if (en_s) begin
                        tmr_load = 1'b1;
                        tmr_val  = SEL_LD;
                    end else if (tmr_done) begin
                        mode_d = txd_s ? MODE_STANDBY : MODE_SLEEP;
                    end else begin
                        tmr_dec = 1'b1;
                    end
                end
                MODE_STANDBY: begin
                    if (en_s) begin
                        mode_d   = MODE_NORMAL;
                        tmr_load = 1'b1;
                        tmr_val  = SEL_LD;
                    end
                end
                MODE_SLEEP: begin
                    if (lin_wake_i || en_s) begin
                        mode_d   = MODE_RESET;
                        tmr_load = 1'b1;
                    end
                end
                default: mode_d = MODE_SHDN;
            endcase
        end
    end

    // Purpose: mode register, Shutdown after block reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SHDN;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Purpose: pin values per mode, with the low-supply override.
    always_comb begin
        rstn_o     = 1'b0;
        vreg_en_o  = 1'b0;
        lin_mode_o = LIN_PASSIVE;
        rxd_o      = 1'b1;
        if (!vs_low_i) begin
            case (mode_q)
                MODE_RESET: begin
                    vreg_en_o = 1'b1;
                    rxd_o     = !wake_pend;
                end
                MODE_NORMAL: begin
                    rstn_o     = 1'b1;
                    vreg_en_o  = 1'b1;
                    lin_mode_o = LIN_ACTIVE;
                    rxd_o      = lin_rx_i;
                end
                MODE_STANDBY: begin
                    rstn_o     = 1'b1;
                    vreg_en_o  = 1'b1;
                    lin_mode_o = LIN_WAKE;
                    rxd_o      = !wake_pend;
                end
                MODE_SLEEP: begin
                    rstn_o     = 1'b1;
                    lin_mode_o = LIN_WAKE;
                    rxd_o      = !wake_pend;
                end
                MODE_THERMAL: begin
                    lin_mode_o = LIN_WAKE;
                    rxd_o      = !wake_pend;
                end
                default: ;
            endcase
        end
    end

    initial begin
        AST_PARAMS_VALID: assert (RST_CYC >= 1 && SEL_CYC >= 1 && SYNC_STG >= 1)
            else $error("bad parameters"); // R4
    end

    AST_SHDN_ON_LOW_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        vs_low_i |=> (mode_q == MODE_SHDN)) else $error("shutdown missed"); // R2

    AST_SHDN_EXITS_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == MODE_SHDN && mode_q != MODE_SHDN) |-> (mode_q == MODE_RESET))
        else $error("bad shutdown exit"); // R3

    AST_RESET_EXIT_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == MODE_RESET && (mode_q == MODE_NORMAL || mode_q == MODE_STANDBY))
        |-> ($past(tmr_done) && !$past(vout_uv_i))) else $error("early reset exit"); // R4

    AST_SLEEP_ONLY_FROM_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SLEEP && $past(mode_q) != MODE_SLEEP) |-> ($past(mode_q) == MODE_NORMAL))
        else $error("sleep from wrong mode"); // R7

    AST_THERMAL_ON_OT: assert property (@(posedge clk) disable iff (!rst_n)
        (overtemp_i && !vs_low_i && mode_q != MODE_SHDN) |=> (mode_q == MODE_THERMAL))
        else $error("thermal missed"); // R11

    AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pend && mode_q != MODE_NORMAL && mode_q != MODE_SHDN) |=> wake_pend)
        else $error("wake lost"); // R9

endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;

    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 6;
    localparam int SEL_CYC    = 4;
    localparam int WD_CYC     = 20000;

    localparam int M_SHDN = 0, M_RST = 1, M_NORM = 2, M_STBY = 3, M_SLP = 4, M_HOT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vs_high = 1'b0, vs_low = 1'b1, uv = 1'b0, ot = 1'b0;
    logic wake = 1'b0, lin_rx = 1'b1, en = 1'b0, txd = 1'b1;
    logic rstn_o, vreg_en_o, rxd_o;
    logic [1:0] lin_mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_mode = M_SHDN;
    int m_cnt  = 0;
    bit m_wake = 1'b0;
    bit en_p[$];
    bit tx_p[$];

    pwr_mode_seq #(.RST_CYC(RST_CYC), .SEL_CYC(SEL_CYC)) i_pwr_mode_seq (
        .clk(clk), .rst_n(rst_n), .vs_high_i(vs_high), .vs_low_i(vs_low),
        .vout_uv_i(uv), .overtemp_i(ot), .lin_wake_i(wake), .lin_rx_i(lin_rx),
        .en_i(en), .txd_i(txd), .rstn_o(rstn_o), .vreg_en_o(vreg_en_o),
        .lin_mode_o(lin_mode_o), .rxd_o(rxd_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Advance the behavioural model by one clock edge, from the pin values.
    task automatic model_step();
        bit ens, txs, nwake;
        int nmode;
        if (!rst_n) begin
            m_mode = M_SHDN; m_cnt = 0; m_wake = 1'b0;
            en_p = '{1'b0, 1'b0}; tx_p = '{1'b1, 1'b1};
            return;
        end
        ens = en_p[0];
        txs = tx_p[0];
        nwake = m_wake;
        if (m_mode == M_NORM || m_mode == M_SHDN) nwake = 1'b0;
        else if (wake && !vs_low && (m_mode == M_STBY || m_mode == M_SLP || m_mode == M_HOT))
            nwake = 1'b1;
        nmode = m_mode;
        if (vs_low) nmode = M_SHDN;
        else if (m_mode == M_SHDN) begin
            if (vs_high && !ot) begin nmode = M_RST; m_cnt = RST_CYC - 1; end
        end else if (m_mode == M_HOT) begin
            if (!ot) begin nmode = M_RST; m_cnt = RST_CYC - 1; end
        end else if (ot) nmode = M_HOT;
        else if (uv && m_mode != M_SLP) begin nmode = M_RST; m_cnt = RST_CYC - 1; end
        else if (m_mode == M_RST) begin
            if (m_cnt == 0) begin nmode = ens ? M_NORM : M_STBY; m_cnt = SEL_CYC - 1; end
            else m_cnt--;
        end else if (m_mode == M_NORM) begin
            if (ens) m_cnt = SEL_CYC - 1;
            else if (m_cnt == 0) nmode = txs ? M_STBY : M_SLP;
            else m_cnt--;
        end else if (m_mode == M_STBY) begin
            if (ens) begin nmode = M_NORM; m_cnt = SEL_CYC - 1; end
        end else if (m_mode == M_SLP) begin
            if (wake || ens) begin nmode = M_RST; m_cnt = RST_CYC - 1; end
        end
        m_mode = nmode;
        m_wake = nwake;
        void'(en_p.pop_front()); en_p.push_back(en);
        void'(tx_p.pop_front()); tx_p.push_back(txd);
    endtask

    // Compare the pins against the model's expectation for the current mode.
    task automatic model_compare();
        int e_rstn, e_vreg, e_lin, e_rxd;
        e_rstn = 0; e_vreg = 0; e_lin = 0; e_rxd = 1;
        if (!vs_low) begin
            case (m_mode)
                M_RST:  begin e_vreg = 1; e_rxd = !m_wake; end
                M_NORM: begin e_rstn = 1; e_vreg = 1; e_lin = 2; e_rxd = lin_rx; end
                M_STBY: begin e_rstn = 1; e_vreg = 1; e_lin = 1; e_rxd = !m_wake; end
                M_SLP:  begin e_rstn = 1; e_lin = 1; e_rxd = !m_wake; end
                M_HOT:  begin e_lin = 1; e_rxd = !m_wake; end
                default: ;
            endcase
        end
        check(cur_req, "model rstn", rstn_o, e_rstn);
        check(cur_req, "model vreg", vreg_en_o, e_vreg);
        check(cur_req, "model lin", lin_mode_o, e_lin);
        check(cur_req, "model rxd", rxd_o, e_rxd);
    endtask

    always @(posedge clk) begin
        model_step();
        #(CLK_PERIOD/4);
        if (!done) model_compare();
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wake();
        wake = 1'b1; step(1); wake = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * WD_CYC);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1: reset state
        check("R1", "rstn", rstn_o, 0); check("R1", "vreg", vreg_en_o, 0);
        check("R1", "lin", lin_mode_o, 0); check("R1", "rxd", rxd_o, 1);
        rst_n = 1'b1;
        cur_req = "R2"; step(3);
        check("R2", "vreg low supply", vreg_en_o, 0);
        // R3: over-temperature blocks exit from Shutdown
        cur_req = "R3"; vs_low = 1'b0; vs_high = 1'b1; ot = 1'b1; step(4);
        check("R3", "vreg held off", vreg_en_o, 0);
        ot = 1'b0; step(2);
        check("R3", "reset entered vreg", vreg_en_o, 1);
        check("R4", "reset rstn", rstn_o, 0);
        // R5: exit with EN low goes to Standby
        cur_req = "R5"; step(RST_CYC + 2);
        check("R5", "standby lin", lin_mode_o, 1); check("R5", "rstn released", rstn_o, 1);
        // R9: wakeup latches in Standby
        cur_req = "R9"; pulse_wake(); step(2);
        check("R9", "standby rxd latched", rxd_o, 0);
        // R6: Standby to Normal, rxd follows receiver
        cur_req = "R6"; en = 1'b1; step(4);
        check("R6", "normal lin", lin_mode_o, 2);
        lin_rx = 1'b0; step(1); check("R6", "rxd follows rx", rxd_o, 0);
        lin_rx = 1'b1; step(1); check("R6", "rxd follows rx high", rxd_o, 1);
        // R7: TxD high picks Standby
        cur_req = "R7"; en = 1'b0; txd = 1'b1; step(2 + SEL_CYC + 3);
        check("R7", "standby chosen", lin_mode_o, 1); check("R7", "standby vreg", vreg_en_o, 1);
        en = 1'b1; step(4);
        // R7: TxD low picks Sleep
        txd = 1'b0; en = 1'b0; step(2 + SEL_CYC + 3);
        check("R7", "sleep vreg", vreg_en_o, 0); check("R7", "sleep lin", lin_mode_o, 1);
        check("R7", "sleep rstn", rstn_o, 1);
        // R10: undervoltage ignored in Sleep, wakeup exits
        cur_req = "R10"; uv = 1'b1; step(3);
        check("R10", "uv ignored in sleep", vreg_en_o, 0);
        uv = 1'b0; txd = 1'b1;
        pulse_wake(); step(1);
        check("R10", "wake to reset vreg", vreg_en_o, 1); check("R10", "wake to reset rstn", rstn_o, 0);
        check("R9", "reset shows wake", rxd_o, 0);
        cur_req = "R9"; step(RST_CYC + 3);
        check("R9", "wake kept in standby", rxd_o, 0);
        en = 1'b1; step(4);
        check("R9", "wake cleared in normal", rxd_o, 1);
        // R8: cancelled request
        cur_req = "R8"; en = 1'b0; step(3); en = 1'b1; step(12);
        check("R8", "stays normal", lin_mode_o, 2);
        // R12 / R4: undervoltage in Normal, restart and exact window
        cur_req = "R12"; uv = 1'b1; step(2);
        check("R12", "uv to reset", rstn_o, 0);
        cur_req = "R4"; step(10);
        check("R4", "held while uv", rstn_o, 0);
        uv = 1'b0; step(RST_CYC - 1);
        check("R4", "still reset one before end", rstn_o, 0);
        step(1);
        check("R4", "released at window end", rstn_o, 1);
        // R11: thermal mode
        cur_req = "R11"; ot = 1'b1; step(2);
        check("R11", "thermal vreg", vreg_en_o, 0); check("R11", "thermal rstn", rstn_o, 0);
        check("R11", "thermal lin", lin_mode_o, 1);
        pulse_wake(); step(1);
        check("R9", "thermal wake", rxd_o, 0);
        ot = 1'b0; step(2);
        check("R11", "back to reset", vreg_en_o, 1);
        step(RST_CYC + 3);
        check("R11", "normal again", lin_mode_o, 2);
        // R13: priority
        cur_req = "R13"; ot = 1'b1; uv = 1'b1; step(2);
        check("R13", "ot over uv", lin_mode_o, 1);
        vs_low = 1'b1; step(2);
        check("R13", "supply over ot", lin_mode_o, 0);
        vs_low = 1'b0; ot = 1'b0; uv = 1'b0; step(RST_CYC + 4);
        check("R13", "recovered", lin_mode_o, 2);
        // R10: EN high leaves Sleep
        cur_req = "R10"; txd = 1'b0; en = 1'b0; step(2 + SEL_CYC + 3);
        check("R10", "in sleep", vreg_en_o, 0);
        en = 1'b1; step(4);
        check("R10", "en to reset", rstn_o, 0); check("R10", "no wake rxd", rxd_o, 1);
        txd = 1'b1; step(RST_CYC + 3);
        check("R5", "exit to normal with en", lin_mode_o, 2);
        // R2: supply drop acts without a clock edge
        cur_req = "R2";
        vs_low = 1'b1; #1;
        check("R2", "async vreg off", vreg_en_o, 0); check("R2", "async rstn low", rstn_o, 0);
        step(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule